// File: doc/BRIEF.md
# Multi-format stereo serial sample receiver

This block sits in front of a stereo converter core. It takes audio samples from a serial link clocked by the bit clock, which is the block's only clock. It puts out one pair of 16-bit channel codes, always in offset binary. A two-bit format input selects one of three link formats.

- **Dual-line parallel format.** Left and right words arrive together on two data lines. A strobe on the frame line marks the end of each pair.
- **Multiplexed offset binary.** Both channels share one data line. The frame line selects the channel.
- **Multiplexed two's complement.** This is the common inter-IC sound framing. It is the same as the multiplexed offset binary format except for the coding.

Words are sent MSB first. Short words are left-aligned. Long words are truncated. Both channel outputs update together at the format's own transfer point, and a one-cycle valid strobe marks each update.

The output side is a plain valid strobe with no ready and no back-pressure. Samples arrive at the link's fixed rate, so the consumer must accept each pair in the cycle the strobe is high. The pair is held until the next strobe.

Top module: `stereo_serial_rx`

## Requirements
- R1: While `rst_n` is low, and after its release until the first transfer, `smp_left` and `smp_right` hold midscale 0x8000 and `smp_valid` is low.
- R2: `fmt_sel` encodings are: 00 dual-line offset binary, 01 multiplexed offset binary, 10 or 11 multiplexed two's complement. The format is loaded during reset, in the cycle of a transfer, and in any cycle where no bit is shifted and none has been collected since the last transfer. A change in the middle of a word takes effect only after that word's transfer.
- R3: In the multiplexed formats, `frame_sync` low selects left and high selects right. The bit sampled on `ser_in0` at a rising edge belongs to the channel given by `frame_sync` at the previous rising edge, so the MSB follows a level change by one bit. `ser_in1` is ignored.
- R4: In the multiplexed formats, a transfer happens at the first rising edge where `frame_sync` is sampled low after being high. The right word includes the bit sampled on that edge. `smp_valid` is high in the following cycle. No transfer happens before a right word has started after reset.
- R5: In the dual-line format, `ser_in0` (left) and `ser_in1` (right) are shifted together on every rising edge where `frame_sync` is sampled low. On edges where it is sampled high, both data lines are ignored.
- R6: In the dual-line format, a transfer happens at the first rising edge where `frame_sync` is sampled high after being low. `smp_valid` is high in the following cycle, and the next word starts empty.
- R7: In two's complement format, bit 15 of each word is inverted on output. In the offset binary formats, words pass unchanged.
- R8: A word with fewer than 16 bits is placed from bit 15 downward, and its unused low bits are zero.
- R9: A word with more than 16 bits keeps only its first 16 bits.
- R10: `smp_valid` is never high for two cycles in a row, and the channel outputs change only in a cycle where `smp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low reset (asynchronous assert) |
| fmt_sel | input | 2 | Link format select |
| frame_sync | input | 1 | Channel select (multiplexed) or latch strobe (dual-line) |
| ser_in0 | input | 1 | Serial data: shared line, or left line |
| ser_in1 | input | 1 | Serial data: right line (dual-line only) |
| smp_valid | output | 1 | One-cycle strobe on each output update |
| smp_left | output | 16 | Left channel code, offset binary |
| smp_right | output | 16 | Right channel code, offset binary |

## Verification
The hardest case to reach from the ports is a format change that lands in the middle of a word. The stimulus must align `fmt_sel` against the internal word boundary, which has no port of its own.

- In the dual-line format, the bench changes `fmt_sel` halfway through the shifted bits. It expects that word to come out without sign inversion.
- In the multiplexed format, the bench changes `fmt_sel` in the middle of a frame. It expects the transfer of that frame to keep the old coding and the next frame to use the new one.

The one-bit delay between the channel select and the data also needs care. The bench builds each frame edge by edge so that the last right bit is sent in the same cycle as the falling select level of the following frame.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    FMT_PAR_OB  = 2'b00,
    FMT_MUX_OB  = 2'b01,
    FMT_MUX_TC  = 2'b10,
    FMT_MUX_TC2 = 2'b11
  } fmt_e;

  localparam int NUM_CH = 2;
  localparam int CH_L   = 0;
  localparam int CH_R   = 1;
endpackage

// File: rtl/srx_line_track.sv
module srx_line_track #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic [STAGES-1:0] hist
);
  // hist[0] = value at previous edge, hist[1] = two edges back, ...
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist[s] <= 1'b1;
      else if (s == 0) hist[s] <= line_in;
      else hist[s] <= hist[(s == 0) ? 0 : s-1];
    end
  end
endmodule

// File: rtl/srx_word_acc.sv
module srx_word_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         word_start,
  input  logic         clear,
  input  logic         din,
  output logic [W-1:0] word_nxt
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    word_nxt = acc;
    cnt_nxt  = cnt;
    if (shift_en) begin
      if (word_start) begin
        word_nxt        = '0;
        word_nxt[W-1]   = din;
        cnt_nxt         = CW'(1);
      end else if (cnt < CW'(W)) begin
        for (int i = 0; i < W; i++) begin
          if (CW'(W - 1 - i) == cnt) word_nxt[i] = din;
        end
        cnt_nxt = cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clear) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= word_nxt;
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/srx_frame_ctrl.sv
module srx_frame_ctrl
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic              sync_now,
  input  logic              sync_d1,
  input  logic              sync_d2,
  input  logic              ser0,
  input  logic              ser1,
  output logic [NUM_CH-1:0] shift_en,
  output logic [NUM_CH-1:0] start,
  output logic [NUM_CH-1:0] bit_in,
  output logic              clear_all,
  output logic              xfer,
  output logic              tc_conv,
  output logic              is_mux
);
  fmt_e act_fmt;
  logic armed;
  logic busy;
  logic fmt_load;

  always_comb begin
    is_mux  = (act_fmt != FMT_PAR_OB);
    tc_conv = (act_fmt == FMT_MUX_TC) || (act_fmt == FMT_MUX_TC2);
    if (is_mux) begin
      shift_en  = sync_d1 ? 2'b10 : 2'b01;
      start     = (sync_d1 != sync_d2) ? shift_en : 2'b00;
      bit_in    = {ser0, ser0};
      xfer      = !sync_now && sync_d1 && armed;
      clear_all = 1'b0;
    end else begin
      shift_en  = {NUM_CH{!sync_now}};
      start     = 2'b00;
      bit_in    = {ser1, ser0};
      xfer      = sync_now && !sync_d1;
      clear_all = xfer;
    end
    fmt_load = xfer || (!busy && !(|shift_en));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fmt_load) act_fmt <= fmt_e'(fmt_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      busy  <= 1'b0;
    end else begin
      armed <= armed || (is_mux && start[CH_R]);
      busy  <= xfer ? 1'b0 : (busy || (|shift_en));
    end
  end
endmodule

// File: rtl/srx_out_stage.sv
module srx_out_stage
  import srx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer,
  input  logic         tc_conv,
  input  logic [W-1:0] word_l,
  input  logic [W-1:0] word_r,
  output logic         valid,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_r
);
  localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] conv [NUM_CH];
  logic [W-1:0] held [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [W-1:0] raw;
    assign raw = (ch == CH_L) ? word_l : word_r;
    assign conv[ch] = tc_conv ? {~raw[W-1], raw[W-2:0]} : raw;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held[ch] <= MIDSCALE;
      else if (xfer) held[ch] <= conv[ch];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else valid <= xfer;
  end

  assign out_l = held[CH_L];
  assign out_r = held[CH_R];
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import srx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                frame_sync,
  input  logic                ser_in0,
  input  logic                ser_in1,
  output logic                smp_valid,
  output logic [SAMPLE_W-1:0] smp_left,
  output logic [SAMPLE_W-1:0] smp_right
);
  localparam int HIST = 2;

  logic [HIST-1:0]     sync_hist;
  logic [NUM_CH-1:0]   shift_en;
  logic [NUM_CH-1:0]   start;
  logic [NUM_CH-1:0]   bit_in;
  logic                clear_all;
  logic                xfer;
  logic                tc_conv;
  logic                mode_is_mux;
  logic [SAMPLE_W-1:0] word_nxt [NUM_CH];

  srx_line_track #(.STAGES(HIST)) u_track (
    .clk     (bit_clk),
    .rst_n   (rst_n),
    .line_in (frame_sync),
    .hist    (sync_hist)
  );

  srx_frame_ctrl u_ctrl (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .sync_now  (frame_sync),
    .sync_d1   (sync_hist[0]),
    .sync_d2   (sync_hist[1]),
    .ser0      (ser_in0),
    .ser1      (ser_in1),
    .shift_en  (shift_en),
    .start     (start),
    .bit_in    (bit_in),
    .clear_all (clear_all),
    .xfer      (xfer),
    .tc_conv   (tc_conv),
    .is_mux    (mode_is_mux)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_acc
    srx_word_acc #(.W(SAMPLE_W)) u_acc (
      .clk        (bit_clk),
      .rst_n      (rst_n),
      .shift_en   (shift_en[ch]),
      .word_start (start[ch]),
      .clear      (clear_all),
      .din        (bit_in[ch]),
      .word_nxt   (word_nxt[ch])
    );
  end

  srx_out_stage #(.W(SAMPLE_W)) u_out (
    .clk     (bit_clk),
    .rst_n   (rst_n),
    .xfer    (xfer),
    .tc_conv (tc_conv),
    .word_l  (word_nxt[CH_L]),
    .word_r  (word_nxt[CH_R]),
    .valid   (smp_valid),
    .out_l   (smp_left),
    .out_r   (smp_right)
  );
endmodule

// File: rtl/stereo_serial_rx_chk.sv
module stereo_serial_rx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sync_in,
  input logic         is_mux,
  input logic         valid,
  input logic [W-1:0] left,
  input logic [W-1:0] right
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  assert_midscale_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (left == MID && right == MID && !valid));

  assert_mux_point_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(is_mux)) |-> (!$past(sync_in) && $past(sync_in, 2)));

  assert_par_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !$past(is_mux)) |-> ($past(sync_in) && !$past(sync_in, 2)));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_left_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left) |-> valid);

  assert_right_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right) |-> valid);
endmodule

bind stereo_serial_rx stereo_serial_rx_chk #(.W(SAMPLE_W)) u_chk (
  .clk     (bit_clk),
  .rst_n   (rst_n),
  .sync_in (frame_sync),
  .is_mux  (mode_is_mux),
  .valid   (smp_valid),
  .left    (smp_left),
  .right   (smp_right)
);

// File: tb/stereo_serial_rx_tb.sv
module stereo_serial_rx_tb_top;
  logic        bit_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        frame_sync = 1'b1;
  logic        ser_in0 = 1'b0;
  logic        ser_in1 = 1'b0;
  logic        smp_valid;
  logic [15:0] smp_left;
  logic [15:0] smp_right;

  int checks = 0;
  int fails  = 0;

  // monitor state
  int          cap_cnt = 0;
  logic [15:0] cap_l = 16'h8000, cap_r = 16'h8000;
  logic        prev_valid = 1'b0;
  logic [15:0] prev_l = 16'h8000, prev_r = 16'h8000;
  int          pulse_err = 0;
  int          chg_err = 0;

  // multiplexed bookkeeping
  logic        pend_bit = 1'b0;
  logic        have_prev = 1'b0;
  logic [15:0] rec_l, rec_r;
  int          rec_n;
  logic        rec_tc;
  logic        cur_tc = 1'b0;

  always #10 bit_clk = ~bit_clk;

  stereo_serial_rx dut_i (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .fmt_sel    (fmt_sel),
    .frame_sync (frame_sync),
    .ser_in0    (ser_in0),
    .ser_in1    (ser_in1),
    .smp_valid  (smp_valid),
    .smp_left   (smp_left),
    .smp_right  (smp_right)
  );

  always @(negedge bit_clk) begin
    if (rst_n) begin
      if (smp_valid) begin
        cap_cnt++;
        cap_l = smp_left;
        cap_r = smp_right;
        if (prev_valid) pulse_err++;
      end else if (smp_left !== prev_l || smp_right !== prev_r) begin
        chg_err++;
      end
      prev_valid = smp_valid;
      prev_l = smp_left;
      prev_r = smp_right;
    end
  end

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [15:0] exp_word(logic [15:0] w, int n, logic tc);
    logic [15:0] m;
    m = (n >= 16) ? w : (w & (16'hFFFF << (16 - n)));
    if (tc) m[15] = ~m[15];
    return m;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic fs, logic d0, logic d1);
    @(negedge bit_clk);
    frame_sync = fs;
    ser_in0 = d0;
    ser_in1 = d1;
  endtask

  function automatic logic word_bit(logic [15:0] w, int i);
    if (i < 16) return w[15 - i];
    return 1'($urandom_range(1));
  endfunction

  task automatic do_reset(logic [1:0] f);
    @(negedge bit_clk);
    rst_n = 1'b0;
    fmt_sel = f;
    frame_sync = 1'b1;
    ser_in0 = 1'b0;
    ser_in1 = 1'b0;
    repeat (3) @(negedge bit_clk);
    rst_n = 1'b1;
    prev_valid = 1'b0;
    prev_l = 16'h8000;
    prev_r = 16'h8000;
  endtask

  // Dual-line word pair, optional format change at bit index chg_at.
  task automatic par_word(logic [15:0] l, logic [15:0] r, int n, int idle,
                          int chg_at, logic [1:0] chg_fmt, string tag);
    int base;
    base = cap_cnt;
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) fmt_sel = chg_fmt;
      drive(1'b0, word_bit(l, i), word_bit(r, i));
    end
    drive(1'b1, 1'($urandom_range(1)), 1'($urandom_range(1)));
    for (int k = 0; k < idle + 2; k++)
      drive(1'b1, 1'($urandom_range(1)), 1'($urandom_range(1)));
    chk({tag, " count"}, 32'(cap_cnt - base), 32'd1);
    chk({tag, " left"}, {16'd0, cap_l}, {16'd0, exp_word(l, n, 1'b0)});
    chk({tag, " right"}, {16'd0, cap_r}, {16'd0, exp_word(r, n, 1'b0)});
  endtask

  // One multiplexed frame of n-bit slots; checks the previous frame.
  task automatic mux_step(logic [15:0] l, logic [15:0] r, int n,
                          int chg_at, logic [1:0] chg_fmt, string tag);
    int base;
    logic new_tc;
    base = cap_cnt;
    new_tc = cur_tc;
    for (int e = 0; e < 2 * n; e++) begin
      logic d;
      if (e == chg_at) begin
        fmt_sel = chg_fmt;
        new_tc = chg_fmt[1];
      end
      if (e == 0) d = pend_bit;
      else if (e <= n) d = word_bit(l, e - 1);
      else d = word_bit(r, e - n - 1);
      drive(e >= n, d, 1'($urandom_range(1)));
    end
    if (have_prev) begin
      chk({tag, " count"}, 32'(cap_cnt - base), 32'd1);
      chk({tag, " left"}, {16'd0, cap_l}, {16'd0, exp_word(rec_l, rec_n, rec_tc)});
      chk({tag, " right"}, {16'd0, cap_r}, {16'd0, exp_word(rec_r, rec_n, rec_tc)});
    end else begin
      chk({tag, " R4 no early transfer"}, 32'(cap_cnt - base), 32'd0);
    end
    pend_bit = word_bit(r, n - 1);
    rec_l = l;
    rec_r = r;
    rec_n = n;
    rec_tc = cur_tc;
    cur_tc = new_tc;
    have_prev = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // Reset state
    do_reset(2'b00);
    @(negedge bit_clk);
    chk("R1 left midscale", {16'd0, smp_left}, 32'h8000);
    chk("R1 right midscale", {16'd0, smp_right}, 32'h8000);
    chk("R1 valid low", {31'd0, smp_valid}, 32'd0);

    // Dual-line format
    for (int t = 0; t < 6; t++)
      par_word(16'($urandom), 16'($urandom), 16, $urandom_range(3), -1, 2'b00,
               "R5 R6 random");
    par_word(16'hFFFF, 16'h0000, 16, 0, -1, 2'b00, "R6 extremes");
    par_word(16'hABCD, 16'h1357, 10, 1, -1, 2'b00, "R8 short");
    par_word(16'h5A5A, 16'hC3C3, 21, 2, -1, 2'b00, "R9 long");
    par_word(16'h8001, 16'h7FFE, 16, 0, 8, 2'b10, "R2 midword change");

    // Multiplexed offset binary
    do_reset(2'b01);
    cur_tc = 1'b0;
    have_prev = 1'b0;
    pend_bit = 1'b0;
    for (int t = 0; t < 5; t++)
      mux_step(16'($urandom), 16'($urandom), 16, -1, 2'b01, "R3 R4 mux ob");
    mux_step(16'hF00F, 16'h0FF0, 12, -1, 2'b01, "R8 mux short");
    mux_step(16'h9669, 16'h3CC3, 19, -1, 2'b01, "R9 mux long");
    mux_step(16'h1234, 16'hFEDC, 16, 20, 2'b10, "R3 mux pre change");
    // Multiplexed two's complement; first check covers the R2 deferral
    mux_step(16'h7FFF, 16'h8000, 16, -1, 2'b10, "R2 deferred format");
    for (int t = 0; t < 4; t++)
      mux_step(16'($urandom), 16'($urandom), 16, -1, 2'b10, "R7 mux tc");
    mux_step(16'h0000, 16'h0000, 16, -1, 2'b10, "R7 mux tc final");

    chk("R10 single-cycle strobe", 32'(pulse_err), 32'd0);
    chk("R10 outputs change only with strobe", 32'(chg_err), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule